// File: doc/BRIEF.md
# Inter-VM Doorbell Register Block

This block holds the register interface of a shared-memory device that links several compute nodes. A host reaches it through a 256-byte window on a simple 32-bit register bus. The window holds four registers: an interrupt mask, an interrupt status that clears when it is read, a read-only register that reports the node's own position, and a write-only doorbell. Data on the bus is little-endian. A build-time option swaps the bytes for hosts that present data big-endian.

A write to the doorbell names a destination node and a vector. The block checks the destination against the number of live nodes. It then checks the vector against the count registered for that node in a small table, which a control port loads. When both checks pass, the block emits a one-cycle notify strobe that carries the node and vector. When either check fails, the write is dropped silently. A local event input loads the value 1 into the status register while message-style signalling is turned off.

The bus side runs as a three-state machine:
- **IDLE** accepts requests. Its transitions are *take_read* to RESP, *take_ring* to RING, and *take_write*, which stays in IDLE.
- **RESP** presents the read data for one cycle, then takes *resp_done* back to IDLE.
- **RING** performs the range checks and drives the notify, then takes *ring_done* back to IDLE.

Top module: `dbreg_top`

## Requirements
- R1: After reset the mask register, the status register and every vector count are zero. Also after reset `req_ready` is 1, and `rd_valid` and `ntf_valid` are 0.
- R2: A write to offset 0x00 stores all 32 bits in the mask register, and a read of 0x00 returns them.
- R3: For writes, only `req_addr[7:0]` is decoded, and bits [1:0] are treated as zero (a write to 0x03 lands in the mask register, and a write to 0x0E rings the doorbell). A read decodes the exact byte offset. A read at any offset that is not 4-byte aligned returns 0 and has no side effect.
- R4: A read of 0x08 returns `own_id`, zero-extended to 32 bits. Writes to 0x08 change nothing.
- R5: Reads of 0x0C (the doorbell) and of every offset above it return 0. Writes to offsets 0x10 and up change no register.
- R6: A read of 0x04 returns the status value, and the same access clears status to 0.
- R7: While `msi_en` is 0, a `local_evt` pulse writes the value 1 into status. While `msi_en` is 1, the pulse leaves status unchanged.
- R8: When an event with `msi_en` 0 coincides with a status read or a status write, the event wins. Status holds 1 afterwards, and a coinciding read still returns the value held before.
- R9: A doorbell write takes the destination from bits [31:16] and the vector from bits [7:0]. Bits [15:8] are ignored. If the write is accepted at edge k, a valid ring raises `ntf_valid` for exactly one cycle after edge k+1, with `ntf_node` and `ntf_vec` set to those fields.
- R10: A doorbell whose destination is at or above min(`known_nodes`, MAX_NODES) produces no notify.
- R11: A doorbell whose vector is at or above the destination's table count produces no notify. A write on the table port (`tbl_we`, `tbl_node`, `tbl_count`) sets that node's count.
- R12: With HOST_BIG_ENDIAN set, `req_wdata` and `rd_data` are byte-reversed at the ports. Register contents and doorbell fields stay little-endian.
- R13: `req_ready` is low for exactly the one cycle that follows an accepted read or doorbell write. `rd_valid` pulses for one cycle, right after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the window |
| req_wdata | input | 32 | Write data (host byte order) |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rd_valid | output | 1 | Read data present |
| rd_data | output | 32 | Read data (host byte order) |
| own_id | input | 16 | This node's position |
| known_nodes | input | 16 | Number of live nodes |
| msi_en | input | 1 | Message-style signalling on; local events bypass status |
| local_evt | input | 1 | Incoming event for this node |
| tbl_we | input | 1 | Vector-count table write strobe |
| tbl_node | input | $clog2(MAX_NODES) | Table entry to write |
| tbl_count | input | CNT_W | Vector count for that node |
| ntf_valid | output | 1 | One-cycle notify strobe |
| ntf_node | output | 16 | Notified node |
| ntf_vec | output | 8 | Notified vector |

## Verification
The bench builds two copies side by side with MAX_NODES = 8 and CNT_W = 9. One copy uses little-endian lanes and the other uses HOST_BIG_ENDIAN = 1. Both copies get the same stimulus, with the write data byte-reversed for the second, so every read and notify also checks the lane swap. Eight table entries let random destinations fall both inside and outside the live-node limit. Setting `known_nodes` above 8 exercises the clamp to MAX_NODES. Small vector counts make both the accepted and the dropped vectors common.

// File: rtl/dbreg_pkg.sv
package dbreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_RING = 2'd2
    } bus_st_t;

    localparam logic [7:0] OFS_MASK = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_POS  = 8'h08;
    localparam logic [7:0] OFS_RING = 8'h0C;

    localparam int NODE_W = 16;
    localparam int VEC_W  = 8;

    typedef struct packed {
        logic [NODE_W-1:0] node;
        logic [VEC_W-1:0]  vec;
    } ring_req_t;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/dbreg_lanes.sv
module dbreg_lanes #(
    parameter bit SWAP = 1'b0
) (
    input  logic [31:0] din,
    output logic [31:0] dout
);
    generate
        if (SWAP) begin : g_swap
            assign dout = dbreg_pkg::swap32(din);
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/dbreg_vtab.sv
module dbreg_vtab #(
    parameter int MAX_NODES = 8,
    parameter int CNT_W     = 9,
    localparam int IDX_W    = $clog2(MAX_NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [CNT_W-1:0] wcount,
    input  logic [IDX_W-1:0] ridx,
    output logic [CNT_W-1:0] rcount
);
    logic [CNT_W-1:0] cnt_q [MAX_NODES];

    generate
        for (genvar g = 0; g < MAX_NODES; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q[g] <= '0;
                end else if (we && (widx == IDX_W'(g))) begin
                    cnt_q[g] <= wcount;
                end
            end
        end
    endgenerate

    always_comb begin
        rcount = '0;
        for (int i = 0; i < MAX_NODES; i++) begin
            if (ridx == IDX_W'(i)) rcount = cnt_q[i];
        end
    end
endmodule

// File: rtl/dbreg_ctrl.sv
module dbreg_ctrl
    import dbreg_pkg::*;
#(
    parameter int MAX_NODES = 8,
    parameter int CNT_W     = 9,
    localparam int IDX_W    = $clog2(MAX_NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       wdata_le,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [31:0]       rdata_le,
    input  logic [NODE_W-1:0] own_id,
    input  logic [NODE_W-1:0] known_nodes,
    input  logic              msi_en,
    input  logic              local_evt,
    output logic [IDX_W-1:0]  tab_idx,
    input  logic [CNT_W-1:0]  tab_count,
    output logic              ntf_valid,
    output logic [NODE_W-1:0] ntf_node,
    output logic [VEC_W-1:0]  ntf_vec
);
    localparam logic [NODE_W:0] MAXN = (NODE_W+1)'(MAX_NODES);

    bus_st_t     st_q, st_d;
    logic [31:0] mask_q, stat_q, rd_q;
    logic        rdv_q, ntf_q;
    ring_req_t   ring_q, ntfp_q;

    logic        acc, acc_rd, acc_wr;
    logic [7:0]  wofs;
    logic [31:0] rd_mux;
    logic [NODE_W:0] eff_nodes;
    logic        node_ok, vec_ok, evt_hit;

    assign req_ready = (st_q == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign acc_rd    = acc && !req_write;
    assign acc_wr    = acc && req_write;
    assign wofs      = {req_addr[7:2], 2'b00};
    assign evt_hit   = local_evt && !msi_en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (acc_rd)                            st_d = ST_RESP;
                else if (acc_wr && wofs == OFS_RING)   st_d = ST_RING;
            end
            ST_RESP: st_d = ST_IDLE;
            ST_RING: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Read decode: exact offset
    always_comb begin
        unique case (req_addr)
            OFS_MASK: rd_mux = mask_q;
            OFS_STAT: rd_mux = stat_q;
            OFS_POS:  rd_mux = {{(32-NODE_W){1'b0}}, own_id};
            default:  rd_mux = '0;
        endcase
    end

    // Range checks on the captured doorbell
    assign eff_nodes = ({1'b0, known_nodes} > MAXN) ? MAXN : {1'b0, known_nodes};
    assign node_ok   = {1'b0, ring_q.node} < eff_nodes;
    assign tab_idx   = ring_q.node[IDX_W-1:0];
    assign vec_ok    = CNT_W'(ring_q.vec) < tab_count;

    // Outputs and registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
            rd_q   <= '0;
            rdv_q  <= 1'b0;
            ntf_q  <= 1'b0;
            ring_q <= '0;
            ntfp_q <= '0;
        end else begin
            rdv_q <= acc_rd;
            if (acc_rd) rd_q <= rd_mux;

            if (acc_wr && wofs == OFS_MASK) mask_q <= wdata_le;

            if (evt_hit)                              stat_q <= 32'd1;
            else if (acc_rd && req_addr == OFS_STAT)  stat_q <= '0;
            else if (acc_wr && wofs == OFS_STAT)      stat_q <= wdata_le;

            if (acc_wr && wofs == OFS_RING) begin
                ring_q.node <= wdata_le[31:16];
                ring_q.vec  <= wdata_le[7:0];
            end

            ntf_q <= (st_q == ST_RING) && node_ok && vec_ok;
            if (st_q == ST_RING) ntfp_q <= ring_q;
        end
    end

    assign rd_valid  = rdv_q;
    assign rdata_le  = rd_q;
    assign ntf_valid = ntf_q;
    assign ntf_node  = ntfp_q.node;
    assign ntf_vec   = ntfp_q.vec;
endmodule

// File: rtl/dbreg_top.sv
module dbreg_top #(
    parameter int MAX_NODES       = 8,
    parameter int CNT_W           = 9,
    parameter bit HOST_BIG_ENDIAN = 1'b0,
    localparam int IDX_W          = $clog2(MAX_NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [7:0]       req_addr,
    input  logic [31:0]      req_wdata,
    output logic             req_ready,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    input  logic [15:0]      own_id,
    input  logic [15:0]      known_nodes,
    input  logic             msi_en,
    input  logic             local_evt,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_node,
    input  logic [CNT_W-1:0] tbl_count,
    output logic             ntf_valid,
    output logic [15:0]      ntf_node,
    output logic [7:0]       ntf_vec
);
    logic [31:0]      wdata_le, rdata_le;
    logic [IDX_W-1:0] tab_idx;
    logic [CNT_W-1:0] tab_count;

    dbreg_lanes #(.SWAP(HOST_BIG_ENDIAN)) u_in_lanes (
        .din (req_wdata),
        .dout(wdata_le)
    );

    dbreg_lanes #(.SWAP(HOST_BIG_ENDIAN)) u_out_lanes (
        .din (rdata_le),
        .dout(rd_data)
    );

    dbreg_vtab #(.MAX_NODES(MAX_NODES), .CNT_W(CNT_W)) u_vtab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_node),
        .wcount(tbl_count),
        .ridx  (tab_idx),
        .rcount(tab_count)
    );

    dbreg_ctrl #(.MAX_NODES(MAX_NODES), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .wdata_le   (wdata_le),
        .req_ready  (req_ready),
        .rd_valid   (rd_valid),
        .rdata_le   (rdata_le),
        .own_id     (own_id),
        .known_nodes(known_nodes),
        .msi_en     (msi_en),
        .local_evt  (local_evt),
        .tab_idx    (tab_idx),
        .tab_count  (tab_count),
        .ntf_valid  (ntf_valid),
        .ntf_node   (ntf_node),
        .ntf_vec    (ntf_vec)
    );
endmodule

// File: rtl/dbreg_chk.sv
module dbreg_chk #(
    parameter int MAX_NODES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_ready,
    input logic        rd_valid,
    input logic [15:0] known_nodes,
    input logic        ntf_valid,
    input logic [15:0] ntf_node
);
    logic [16:0] eff;
    assign eff = ({1'b0, known_nodes} > 17'(MAX_NODES)) ? 17'(MAX_NODES) : {1'b0, known_nodes};

    // R13
    read_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rd_valid && !req_ready));

    // R13
    rdv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_ready && !req_write));

    // R9
    ntf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |=> !ntf_valid);

    // R9
    ntf_after_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> $past(!req_ready));

    // R10
    ntf_node_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> ({1'b0, ntf_node} < $past(eff)));
endmodule

bind dbreg_top dbreg_chk #(.MAX_NODES(MAX_NODES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .known_nodes(known_nodes),
    .ntf_valid  (ntf_valid),
    .ntf_node   (ntf_node)
);

// File: tb/dbreg_top_tb_top.sv
module dbreg_top_tb_top;
    localparam logic [15:0] OWN = 16'h0003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [7:0]  req_addr = 0;
    logic [31:0] wdata = 0;
    logic [15:0] known_nodes = 0;
    logic        msi_en = 0, local_evt = 0, tbl_we = 0;
    logic [2:0]  tbl_node = 0;
    logic [8:0]  tbl_count = 0;

    logic        rdy, rdv, nv, rdy_s, rdv_s, nv_s;
    logic [31:0] rdd, rdd_s;
    logic [15:0] nn, nn_s;
    logic [7:0]  nvec, nvec_s;

    dbreg_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(wdata), .req_ready(rdy), .rd_valid(rdv),
        .rd_data(rdd), .own_id(OWN), .known_nodes(known_nodes), .msi_en(msi_en),
        .local_evt(local_evt), .tbl_we(tbl_we), .tbl_node(tbl_node),
        .tbl_count(tbl_count), .ntf_valid(nv), .ntf_node(nn), .ntf_vec(nvec));

    dbreg_top #(.HOST_BIG_ENDIAN(1'b1)) dut_swap_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(dbreg_pkg::swap32(wdata)), .req_ready(rdy_s),
        .rd_valid(rdv_s), .rd_data(rdd_s), .own_id(OWN), .known_nodes(known_nodes),
        .msi_en(msi_en), .local_evt(local_evt), .tbl_we(tbl_we), .tbl_node(tbl_node),
        .tbl_count(tbl_count), .ntf_valid(nv_s), .ntf_node(nn_s), .ntf_vec(nvec_s));

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] m_mask = 0, m_stat = 0;
    int m_cnt [8];
    int m_known = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic ring_ok(input logic [31:0] d);
        int eff = (m_known > 8) ? 8 : m_known;
        int node = int'(d[31:16]);
        if (node >= eff) return 1'b0;
        return int'(d[7:0]) < m_cnt[node];
    endfunction

    function automatic logic [31:0] rd_model(input logic [7:0] a);
        case (a)
            8'h00:   return m_mask;
            8'h04:   return m_stat;
            8'h08:   return {16'h0, OWN};
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic ev);
        @(negedge clk);
        while (!rdy) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; wdata = d; local_evt = ev;
        @(negedge clk);
        req_valid = 0; req_write = 0; local_evt = 0;
        if ({a[7:2], 2'b00} == 8'h00) m_mask = d;
        if ({a[7:2], 2'b00} == 8'h04) m_stat = d;
        if (ev && !msi_en) m_stat = 32'd1;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic ev, input string tag);
        logic [31:0] e;
        @(negedge clk);
        while (!rdy) @(negedge clk);
        e = rd_model(a);
        req_valid = 1; req_write = 0; req_addr = a; local_evt = ev;
        @(negedge clk);
        req_valid = 0; local_evt = 0;
        chk({tag, " rd_valid"}, {31'b0, rdv}, 32'd1);
        chk({tag, " R13 ready low"}, {31'b0, rdy}, 32'd0);
        chk({tag, " rd_data"}, rdd, e);
        chk({tag, " R12 swapped rd_data"}, rdd_s, dbreg_pkg::swap32(e));
        if (a == 8'h04) m_stat = 32'd0;
        if (ev && !msi_en) m_stat = 32'd1;
    endtask

    task automatic ring(input logic [7:0] a, input logic [31:0] d, input string tag);
        logic f;
        f = ring_ok(d);
        bus_wr(a, d, 1'b0);
        chk({tag, " R13 ready low"}, {31'b0, rdy}, 32'd0);
        chk({tag, " no early ntf"}, {31'b0, nv}, 32'd0);
        @(negedge clk);
        chk({tag, " ntf_valid"}, {31'b0, nv}, {31'b0, f});
        chk({tag, " R12 swap ntf_valid"}, {31'b0, nv_s}, {31'b0, f});
        if (f) begin
            chk({tag, " ntf_node"}, {16'h0, nn}, {16'h0, d[31:16]});
            chk({tag, " ntf_vec"}, {24'h0, nvec}, {24'h0, d[7:0]});
            chk({tag, " R12 swap ntf_node"}, {16'h0, nn_s}, {16'h0, d[31:16]});
        end
        @(negedge clk);
        chk({tag, " R9 one cycle"}, {31'b0, nv}, 32'd0);
    endtask

    task automatic tbl(input int n, input int c);
        @(negedge clk);
        tbl_we = 1; tbl_node = 3'(n); tbl_count = 9'(c);
        @(negedge clk);
        tbl_we = 0;
        m_cnt[n] = c;
    endtask

    initial begin
        logic [7:0] rd_addrs [7];
        rd_addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h01, 8'h05, 8'h20};
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 ready", {31'b0, rdy}, 32'd1);
        chk("R1 rd_valid", {31'b0, rdv}, 32'd0);
        chk("R1 ntf", {31'b0, nv}, 32'd0);
        bus_rd(8'h00, 0, "R1 mask");
        bus_rd(8'h04, 0, "R1 stat");

        known_nodes = 16'd4; m_known = 4;
        ring(8'h0C, 32'h0000_0000, "R1 R11 zero count drop");
        tbl(0, 3); tbl(2, 1);
        ring(8'h0C, 32'h0000_0002, "R9 fire");
        ring(8'h0C, 32'h0000_FF02, "R9 mid byte ignored");
        ring(8'h0C, 32'h0000_0003, "R11 vec drop");
        ring(8'h0C, 32'h0002_0000, "R11 node2 fire");
        ring(8'h0C, 32'h0002_0001, "R11 node2 drop");
        ring(8'h0C, 32'h0004_0000, "R10 node drop");
        ring(8'h0C, 32'hFFFF_0000, "R10 max node drop");
        tbl(5, 2);
        known_nodes = 16'd20; m_known = 20;
        ring(8'h0C, 32'h0005_0001, "R10 clamp fire");
        ring(8'h0C, 32'h0008_0000, "R10 clamp drop");
        ring(8'h0E, 32'h0000_0001, "R3 ring unaligned");

        bus_wr(8'h00, 32'hDEAD_BEEF, 0);
        bus_rd(8'h00, 0, "R2 mask");
        bus_wr(8'h03, 32'h1234_5678, 0);
        bus_rd(8'h00, 0, "R3 write low bits");
        bus_rd(8'h01, 0, "R3 unaligned read");

        bus_rd(8'h08, 0, "R4 pos");
        bus_wr(8'h08, 32'hFFFF_FFFF, 0);
        bus_rd(8'h08, 0, "R4 pos after write");
        bus_rd(8'h00, 0, "R4 mask untouched");

        bus_rd(8'h0C, 0, "R5 doorbell read");
        bus_rd(8'h40, 0, "R5 undef read");
        bus_rd(8'hFC, 0, "R5 top read");
        bus_wr(8'h40, 32'hCAFE_F00D, 0);
        bus_rd(8'h00, 0, "R5 mask after undef write");
        bus_rd(8'h04, 0, "R5 stat after undef write");

        bus_wr(8'h04, 32'hA5A5_0001, 0);
        bus_rd(8'h05, 0, "R3 unaligned no clear");
        bus_rd(8'h04, 0, "R6 stat value");
        bus_rd(8'h04, 0, "R6 stat cleared");

        msi_en = 0;
        @(negedge clk); local_evt = 1; @(negedge clk); local_evt = 0; m_stat = 1;
        bus_rd(8'h04, 0, "R7 event sets 1");
        msi_en = 1;
        bus_wr(8'h04, 32'h0000_0077, 0);
        @(negedge clk); local_evt = 1; @(negedge clk); local_evt = 0;
        bus_rd(8'h04, 0, "R7 msi event ignored");
        msi_en = 0;

        bus_wr(8'h04, 32'h0000_ABCD, 0);
        bus_rd(8'h04, 1, "R8 read with event");
        bus_rd(8'h04, 0, "R8 event kept");
        bus_wr(8'h04, 32'h0000_0055, 1);
        bus_rd(8'h04, 0, "R8 event beats write");

        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom % 5);
            case (op)
                0: begin
                    logic [31:0] d;
                    d = {16'($urandom % 11), 8'($urandom), 8'($urandom % 6)};
                    if ($urandom % 9 == 0) d[31:16] = 16'($urandom);
                    ring(8'h0C | 8'($urandom % 4), d, "R9 R10 R11 random ring");
                end
                1: begin
                    bus_wr(8'h00 | 8'($urandom % 4), $urandom, 0);
                    bus_rd(8'h00, 0, "R2 random mask");
                end
                2: tbl(int'($urandom % 8), int'($urandom % 6));
                3: begin
                    bus_wr(8'h04, $urandom, 0);
                    bus_rd(8'h04, 0, "R6 random stat");
                end
                default: bus_rd(rd_addrs[$urandom % 7], 0, "R3 R5 random read");
            endcase
            if (it == 150) begin known_nodes = 16'd6; m_known = 6; end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule